// File: doc/BRIEF.md
# Packet Info Page Delay

This block holds the per-packet side information of a stream for exactly one buffer period, so that it can be rejoined with payload that comes back out of a two-page data buffer one period after it went in. When an incoming packet starts, its sync flag, sequence number and channel field are stored. When it ends, its error and empty fields are stored. All of these writes go into the page that is currently being written.

A pulse on `store_done` marks the point where the data buffer has finished filling a page. On that pulse the info register swaps its pages too. Output info is always read from the page that is not being written. A merge stage then builds the output stream. Payload and framing come from the retrieved-data inputs in the same cycle. Sync and sequence number are attached only on the output start-of-packet cycle. Error and empty are attached only on the output end-of-packet cycle. The channel field is presented continuously. The data buffer and the generation of the retrieved stream are not part of this block.

Top module: `pkt_info_delay`

## Requirements
- R1: When `in_sop` is 1 at a clock edge, `in_sync`, `in_seq` and `in_chan` are stored into the current write page. A read page is never overwritten by these inputs.
- R2: When `in_eop` is 1 at a clock edge, `in_err` and `in_empty` are stored into the current write page.
- R3: After reset every stored field in both pages is 0, the write page index is 0 and the read page is page 1. With the retrieved inputs all at 1 during reset, every info output reads 0.
- R4: There are exactly two pages. Each `store_done` pulse swaps the write and read pages on that edge. Without a pulse the pages stay as they are. The info outputs come from the page that is not being written.
- R5: If `in_sop` and `store_done` are both 1 at the same edge, the sop-time fields go into the page that was being written before the swap. They are therefore visible on the outputs in the very next cycle.
- R6: `out_valid`, `out_sop`, `out_eop` and `out_data` equal `ret_valid`, `ret_sop`, `ret_eop` and `ret_data` in the same cycle, with no register in between.
- R7: `out_sync` and `out_seq` carry the read page's values only when `ret_sop` is 1, and are 0 otherwise. `out_err` and `out_empty` carry the read page's values only when `ret_eop` is 1, and are 0 otherwise. `out_chan` always shows the read page's channel field.
- R8: If `in_eop` and `store_done` are both 1 at the same edge, the eop-time fields go into the page that was being written before the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| in_sync | input | 1 | Input sync flag, sampled at start of packet |
| in_seq | input | SEQ_W | Input block sequence number, sampled at start of packet |
| in_chan | input | CHAN_W | Input channel field, sampled at start of packet |
| in_err | input | ERR_W | Input error field, sampled at end of packet |
| in_empty | input | EMPTY_W | Input empty count, sampled at end of packet |
| store_done | input | 1 | One-cycle pulse: the data buffer finished a page, so the info pages swap |
| ret_valid | input | 1 | Retrieved stream valid |
| ret_sop | input | 1 | Retrieved stream start of packet |
| ret_eop | input | 1 | Retrieved stream end of packet |
| ret_data | input | DATA_W | Retrieved stream payload |
| out_valid | output | 1 | Output valid |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_data | output | DATA_W | Output payload |
| out_sync | output | 1 | Delayed sync flag, only in the sop cycle |
| out_seq | output | SEQ_W | Delayed sequence number, only in the sop cycle |
| out_chan | output | CHAN_W | Delayed channel field |
| out_err | output | ERR_W | Delayed error field, only in the eop cycle |
| out_empty | output | EMPTY_W | Delayed empty count, only in the eop cycle |

## Verification
The bench builds the block with its default widths: 32-bit sequence and data, 16-bit channel, 8-bit error and 4-bit empty. At these widths every field is wide enough to hold a distinct value for each packet, and one packet sends all-ones values so that no bit stays untested. Each of the two pages is written and read several times. The bench includes idle cycles between blocks, swaps that fall on the same edge as a start of packet and as an end of packet, and a start of packet written after the swap, which must stay hidden until the next swap.

// File: rtl/pid_pkg.sv
package pid_pkg;

  localparam int PID_PAGES = 2;

  typedef enum logic {
    PG_A = 1'b0,
    PG_B = 1'b1
  } pid_page_e;

  function automatic pid_page_e pid_other(input pid_page_e p);
    return (p == PG_A) ? PG_B : PG_A;
  endfunction

endpackage

// File: rtl/pid_page_ctrl.sv
module pid_page_ctrl
  import pid_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      swap,
  output pid_page_e wr_page,
  output pid_page_e rd_page
);

  pid_page_e page_q;
  pid_page_e page_d;

  always_comb begin
    page_d = page_q;
    if (swap) begin
      page_d = pid_other(page_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= PG_A;
    end else begin
      page_q <= page_d;
    end
  end

  assign wr_page = page_q;
  assign rd_page = pid_other(page_q);

endmodule

// File: rtl/pid_page_bank.sv
module pid_page_bank
  import pid_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  pid_page_e    wr_sel,
  input  logic [W-1:0] wr_data,
  input  pid_page_e    rd_sel,
  output logic [W-1:0] rd_data
);

  logic [W-1:0] page_val [PID_PAGES];

  for (genvar g = 0; g < PID_PAGES; g++) begin : g_page
    logic         hit;
    logic [W-1:0] val_q;
    logic [W-1:0] val_d;

    always_comb begin
      hit   = wr_en && (int'(wr_sel) == g);
      val_d = val_q;
      if (hit) begin
        val_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= val_d;
      end
    end

    assign page_val[g] = val_q;
  end

  assign rd_data = page_val[rd_sel];

endmodule

// File: rtl/pid_combine.sv
module pid_combine #(
  parameter int SEQ_W   = 32,
  parameter int CHAN_W  = 16,
  parameter int ERR_W   = 8,
  parameter int EMPTY_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic               ret_valid,
  input  logic               ret_sop,
  input  logic               ret_eop,
  input  logic [DATA_W-1:0]  ret_data,
  input  logic               pg_sync,
  input  logic [SEQ_W-1:0]   pg_seq,
  input  logic [CHAN_W-1:0]  pg_chan,
  input  logic [ERR_W-1:0]   pg_err,
  input  logic [EMPTY_W-1:0] pg_empty,
  output logic               out_valid,
  output logic               out_sop,
  output logic               out_eop,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_sync,
  output logic [SEQ_W-1:0]   out_seq,
  output logic [CHAN_W-1:0]  out_chan,
  output logic [ERR_W-1:0]   out_err,
  output logic [EMPTY_W-1:0] out_empty
);

  always_comb begin
    out_valid = ret_valid;
    out_sop   = ret_sop;
    out_eop   = ret_eop;
    out_data  = ret_data;
    out_chan  = pg_chan;
    out_sync  = 1'b0;
    out_seq   = '0;
    out_err   = '0;
    out_empty = '0;
    if (ret_sop) begin
      out_sync = pg_sync;
      out_seq  = pg_seq;
    end
    if (ret_eop) begin
      out_err   = pg_err;
      out_empty = pg_empty;
    end
  end

endmodule

// File: rtl/pkt_info_delay.sv
module pkt_info_delay
  import pid_pkg::*;
#(
  parameter int SEQ_W   = 32,
  parameter int CHAN_W  = 16,
  parameter int ERR_W   = 8,
  parameter int EMPTY_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic               in_sync,
  input  logic [SEQ_W-1:0]   in_seq,
  input  logic [CHAN_W-1:0]  in_chan,
  input  logic [ERR_W-1:0]   in_err,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic               store_done,
  input  logic               ret_valid,
  input  logic               ret_sop,
  input  logic               ret_eop,
  input  logic [DATA_W-1:0]  ret_data,
  output logic               out_valid,
  output logic               out_sop,
  output logic               out_eop,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_sync,
  output logic [SEQ_W-1:0]   out_seq,
  output logic [CHAN_W-1:0]  out_chan,
  output logic [ERR_W-1:0]   out_err,
  output logic [EMPTY_W-1:0] out_empty
);

  localparam int HEAD_W = 1 + SEQ_W + CHAN_W;
  localparam int TAIL_W = ERR_W + EMPTY_W;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  pid_page_e wr_page;
  pid_page_e rd_page;

  pid_page_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .swap    (store_done),
    .wr_page (wr_page),
    .rd_page (rd_page)
  );

  logic [HEAD_W-1:0] head_wr;
  logic [HEAD_W-1:0] head_rd;
  logic [TAIL_W-1:0] tail_wr;
  logic [TAIL_W-1:0] tail_rd;

  assign head_wr = {in_sync, in_seq, in_chan};
  assign tail_wr = {in_err, in_empty};

  pid_page_bank #(.W(HEAD_W)) i_head (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (in_sop),
    .wr_sel  (wr_page),
    .wr_data (head_wr),
    .rd_sel  (rd_page),
    .rd_data (head_rd)
  );

  pid_page_bank #(.W(TAIL_W)) i_tail (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (in_eop),
    .wr_sel  (wr_page),
    .wr_data (tail_wr),
    .rd_sel  (rd_page),
    .rd_data (tail_rd)
  );

  logic               pg_sync;
  logic [SEQ_W-1:0]   pg_seq;
  logic [CHAN_W-1:0]  pg_chan;
  logic [ERR_W-1:0]   pg_err;
  logic [EMPTY_W-1:0] pg_empty;

  assign {pg_sync, pg_seq, pg_chan} = head_rd;
  assign {pg_err, pg_empty}         = tail_rd;

  pid_combine #(
    .SEQ_W   (SEQ_W),
    .CHAN_W  (CHAN_W),
    .ERR_W   (ERR_W),
    .EMPTY_W (EMPTY_W),
    .DATA_W  (DATA_W)
  ) i_merge (
    .ret_valid (ret_valid),
    .ret_sop   (ret_sop),
    .ret_eop   (ret_eop),
    .ret_data  (ret_data),
    .pg_sync   (pg_sync),
    .pg_seq    (pg_seq),
    .pg_chan   (pg_chan),
    .pg_err    (pg_err),
    .pg_empty  (pg_empty),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data),
    .out_sync  (out_sync),
    .out_seq   (out_seq),
    .out_chan  (out_chan),
    .out_err   (out_err),
    .out_empty (out_empty)
  );

endmodule

// File: rtl/pid_info_chk.sv
module pid_info_chk
  import pid_pkg::*;
#(
  parameter int SEQ_W   = 32,
  parameter int ERR_W   = 8,
  parameter int EMPTY_W = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               store_done,
  input pid_page_e          wr_page,
  input pid_page_e          rd_page,
  input logic               ret_valid,
  input logic               ret_sop,
  input logic               ret_eop,
  input logic [DATA_W-1:0]  ret_data,
  input logic               out_valid,
  input logic               out_sop,
  input logic               out_eop,
  input logic [DATA_W-1:0]  out_data,
  input logic               out_sync,
  input logic [SEQ_W-1:0]   out_seq,
  input logic [ERR_W-1:0]   out_err,
  input logic [EMPTY_W-1:0] out_empty
);

  AST_PAGE_SWAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    store_done |=> (wr_page != $past(wr_page))); // R4

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !store_done |=> $stable(wr_page)); // R4

  AST_PAGE_APART: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_page != wr_page); // R4

  AST_SOP_GATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ret_sop |-> (!out_sync && out_seq == '0)); // R7

  AST_EOP_GATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ret_eop |-> (out_err == '0 && out_empty == '0)); // R7

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid == ret_valid) && (out_sop == ret_sop) &&
    (out_eop == ret_eop) && (out_data == ret_data)); // R6

endmodule

bind pkt_info_delay pid_info_chk #(
  .SEQ_W   (SEQ_W),
  .ERR_W   (ERR_W),
  .EMPTY_W (EMPTY_W),
  .DATA_W  (DATA_W)
) i_info_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .store_done (store_done),
  .wr_page    (wr_page),
  .rd_page    (rd_page),
  .ret_valid  (ret_valid),
  .ret_sop    (ret_sop),
  .ret_eop    (ret_eop),
  .ret_data   (ret_data),
  .out_valid  (out_valid),
  .out_sop    (out_sop),
  .out_eop    (out_eop),
  .out_data   (out_data),
  .out_sync   (out_sync),
  .out_seq    (out_seq),
  .out_err    (out_err),
  .out_empty  (out_empty)
);

// File: tb/test_pkt_info_delay.sv
module test_pkt_info_delay;

  localparam int SEQ_W   = 32;
  localparam int CHAN_W  = 16;
  localparam int ERR_W   = 8;
  localparam int EMPTY_W = 4;
  localparam int DATA_W  = 32;

  logic clk;
  logic rst_n;
  logic in_sop, in_eop, in_sync, store_done;
  logic [SEQ_W-1:0]   in_seq;
  logic [CHAN_W-1:0]  in_chan;
  logic [ERR_W-1:0]   in_err;
  logic [EMPTY_W-1:0] in_empty;
  logic ret_valid, ret_sop, ret_eop;
  logic [DATA_W-1:0]  ret_data;
  logic out_valid, out_sop, out_eop, out_sync;
  logic [DATA_W-1:0]  out_data;
  logic [SEQ_W-1:0]   out_seq;
  logic [CHAN_W-1:0]  out_chan;
  logic [ERR_W-1:0]   out_err;
  logic [EMPTY_W-1:0] out_empty;

  pkt_info_delay i_pkt_info_delay (
    .clk(clk), .rst_n(rst_n),
    .in_sop(in_sop), .in_eop(in_eop), .in_sync(in_sync), .in_seq(in_seq),
    .in_chan(in_chan), .in_err(in_err), .in_empty(in_empty),
    .store_done(store_done),
    .ret_valid(ret_valid), .ret_sop(ret_sop), .ret_eop(ret_eop), .ret_data(ret_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .out_sync(out_sync), .out_seq(out_seq), .out_chan(out_chan),
    .out_err(out_err), .out_empty(out_empty)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic               v;
    logic               s;
    logic               e;
    logic [DATA_W-1:0]  d;
    logic               sy;
    logic [SEQ_W-1:0]   sq;
    logic [CHAN_W-1:0]  ch;
    logic [ERR_W-1:0]   er;
    logic [EMPTY_W-1:0] em;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_cmp = 0;
  int n_bad = 0;

  // reference model of the two pages
  logic               m_sync  [2];
  logic [SEQ_W-1:0]   m_seq   [2];
  logic [CHAN_W-1:0]  m_chan  [2];
  logic [ERR_W-1:0]   m_err   [2];
  logic [EMPTY_W-1:0] m_empty [2];
  int m_wr;

  task automatic chk(input string req, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s/%s %s: actual=%h expected=%h at %0t", req, tag, what, act, expv, $time);
    end
  endtask

  task automatic cyc(input logic isop, input logic ieop, input logic isync,
                     input logic [SEQ_W-1:0] iseq, input logic [CHAN_W-1:0] ichan,
                     input logic [ERR_W-1:0] ierr, input logic [EMPTY_W-1:0] iempty,
                     input logic isd, input logic rv, input logic rs, input logic re,
                     input logic [DATA_W-1:0] rd, input string tag);
    exp_t e;
    int rp;
    in_sop = isop; in_eop = ieop; in_sync = isync; in_seq = iseq;
    in_chan = ichan; in_err = ierr; in_empty = iempty; store_done = isd;
    ret_valid = rv; ret_sop = rs; ret_eop = re; ret_data = rd;
    rp   = 1 - m_wr;
    e.v  = rv; e.s = rs; e.e = re; e.d = rd;
    e.sy = rs ? m_sync[rp] : 1'b0;
    e.sq = rs ? m_seq[rp]  : '0;
    e.ch = m_chan[rp];
    e.er = re ? m_err[rp]   : '0;
    e.em = re ? m_empty[rp] : '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    if (isop) begin
      m_sync[m_wr] = isync; m_seq[m_wr] = iseq; m_chan[m_wr] = ichan;
    end
    if (ieop) begin
      m_err[m_wr] = ierr; m_empty[m_wr] = iempty;
    end
    if (isd) m_wr = 1 - m_wr;
    #1;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, '0, '0, '0, '0, 0, 0, 0, 0, '0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk("R6", t, "valid/sop/eop", {61'd0, out_valid, out_sop, out_eop}, {61'd0, e.v, e.s, e.e});
      chk("R6", t, "data", 64'(out_data), 64'(e.d));
      chk("R1", t, "sync", 64'(out_sync), 64'(e.sy));
      chk("R1", t, "seq", 64'(out_seq), 64'(e.sq));
      chk("R1", t, "chan", 64'(out_chan), 64'(e.ch));
      chk("R2", t, "err", 64'(out_err), 64'(e.er));
      chk("R2", t, "empty", 64'(out_empty), 64'(e.em));
    end
  end

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL R4 watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      m_sync[p] = 0; m_seq[p] = '0; m_chan[p] = '0; m_err[p] = '0; m_empty[p] = '0;
    end
    m_wr = 0;
    rst_n = 1'b0;
    @(posedge clk); #1;
    // R3: retrieved flags high during reset, all info must read zero
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0, '0, '0, '0, 0, 1, 1, 1, 32'h1234, "R3");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0, '0, '0, '0, 0, 1, 1, 1, 32'h5678, "R3");

    // R4/R8: blocks of four cycles, eop and swap share the last edge
    for (int b = 0; b < 6; b++) begin
      logic [SEQ_W-1:0]   sq;
      logic [CHAN_W-1:0]  ch;
      logic [ERR_W-1:0]   er;
      logic [EMPTY_W-1:0] em;
      logic               sy;
      sq = 32'hA000_0000 + 32'(b * 257);
      ch = 16'(b * 3 + 1);
      er = 8'(b + 1);
      em = 4'(b);
      sy = b[0];
      if (b == 4) begin
        sq = '1; ch = '1; er = '1; em = '1; sy = 1'b1;
      end
      cyc(1, 0, sy, sq, ch, '0, '0, 0, 1, 1, 0, 32'(b * 100), "R4");
      cyc(0, 0, 0, '0, '0, '0, '0, 0, 1, 0, 0, 32'(b * 100 + 1), "R7");
      cyc(0, 0, 0, '0, '0, '0, '0, 0, 1, 0, 0, 32'(b * 100 + 2), "R7");
      cyc(0, 1, 0, '0, '0, er, em, 1, 1, 0, 1, 32'(b * 100 + 3), "R8");
      if (b == 2) idle("R7");
    end

    // R5: sop together with swap lands in the page just turned to read
    cyc(1, 0, 1, 32'hC0DE_0001, 16'h0BAD, '0, '0, 1, 0, 0, 0, '0, "R5");
    cyc(0, 0, 0, '0, '0, '0, '0, 0, 1, 1, 1, 32'hD1, "R5");
    // R1: sop without swap goes to the write page and stays hidden
    cyc(1, 1, 0, 32'hC0DE_0002, 16'h0FED, 8'h77, 4'h9, 0, 0, 0, 0, '0, "R1");
    cyc(0, 0, 0, '0, '0, '0, '0, 0, 1, 1, 1, 32'hD2, "R1");
    cyc(0, 0, 0, '0, '0, '0, '0, 1, 0, 0, 0, '0, "R4");
    cyc(0, 0, 0, '0, '0, '0, '0, 0, 1, 1, 1, 32'hD3, "R4");
    idle("R7");

    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule